// File: doc/BRIEF.md
# DMA Page and Address Generator

This block produces the physical address and the byte length of a transfer for each of four DMA channels. For every channel it keeps two page bytes: a low page for address bits 23:16 and a high page for bits 30:24. Software writes and reads these bytes through an eight-entry I/O port window. The low page and high page banks are told apart by a bank-select input.

The channel's address counter, the direction bit from its mode register, its transfer position and its programmed count all come in from outside. The block picks the slice for the selected channel and forms the effective address. In word mode the base address is doubled to give a byte address. The position is added to that address, or subtracted from it when the channel counts downward. The page bytes are then placed above the result, and the transfer length in bytes is worked out.

Both results are registered. The port window maps offsets to channels in a fixed, non-linear order, and some offsets are holes. Parameters select byte or word width and whether the high page bank exists at all.

Top module: `dma_page_addr_gen`

## Requirements
- R1: Port offsets map to channels as follows: offset 7 to channel 0, offset 3 to channel 1, offset 1 to channel 2 and offset 2 to channel 3. A write with `io_hi`=0 loads the channel's low page, and a write with `io_hi`=1 loads its high page. A read with `io_rd` returns the addressed byte on `io_rdata` after the next clock edge.
- R2: Offsets 0, 4, 5 and 6 are holes. A write to a hole changes no page register. A read from a hole returns 0 on `io_rdata` and raises `io_err` for exactly one cycle, after the same edge.
- R3: `phys_addr` = ((high page AND 0x7F) << 24) OR (low page << 16) OR effective address. Bit 31 is therefore always 0.
- R4: When the selected channel's bit in `ch_dir` is 1, the effective address is the start address minus the position. When the bit is 0, it is the start address plus the position. The result wraps modulo 2^(16+word shift).
- R5: With WORD_MODE=1, the start address is `cur_addr` shifted left by 1, so the effective address is 17 bits wide. With WORD_MODE=0, the start address is `cur_addr` unchanged.
- R6: With HIGH_PAGE_EN=0 there are no high page registers. High page writes have no effect. High page reads return 0 and do not raise `io_err`. `phys_addr` bits 30:24 stay 0.
- R7: `xfer_len` = (base count + 1) << word shift. It is 17 bits wide in byte mode and 18 bits wide in word mode.
- R8: After reset, every page register, `phys_addr`, `xfer_len`, `io_rdata` and `io_err` are 0.
- R9: `phys_addr` and `xfer_len` are registered. They reflect `ch_sel` and the channel inputs sampled at the previous clock edge, and they do not change between edges.
- R10: A high page register keeps all 8 written bits, and a read returns all 8. Only the address output drops bit 7.
- R11: When a read and a write address the same page port in one cycle, the read returns the value held before the write. The next read returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_off | input | 3 | Page port offset within the window |
| io_hi | input | 1 | 1 selects the high page bank, 0 selects the low page bank |
| io_wr | input | 1 | Write strobe for the page window |
| io_rd | input | 1 | Read strobe for the page window |
| io_wdata | input | 8 | Page write data |
| io_rdata | output | 8 | Registered page read data |
| io_err | output | 1 | One-cycle flag raised after a read from a hole |
| ch_sel | input | 2 | Channel whose address is composed |
| cur_addr | input | 64 | Current address of each channel, 16 bits per channel, channel 0 in the low bits |
| cur_pos | input | 64 | Transfer position of each channel in bytes, 16 bits per channel |
| base_cnt | input | 64 | Programmed count of each channel, 16 bits per channel |
| ch_dir | input | 4 | Per-channel downward-count bit, taken from mode register bit 5 |
| phys_addr | output | 32 | Registered physical address |
| xfer_len | output | 17 (18 in word mode) | Registered transfer length in bytes |

## Verification
A page port read and a write to that same port can fall in the same clock cycle, because the window has separate read and write strobes. The bench asserts both strobes together on a mapped port. It expects `io_rdata` to show the old byte, and a later read to show the new one. A page write can also land in the same cycle as an address composition. The bench therefore checks composed addresses only after the page programming has settled, and it checks separately that a write to a hole leaves both the read-back bytes and the address unchanged.

// File: rtl/dma_pg_pkg.sv
package dma_pg_pkg;
   localparam int PORT_OFF_W = 3;
   localparam int CH_IDX_W   = 2;

   typedef struct packed {
      logic                hit;
      logic [CH_IDX_W-1:0] ch;
   } port_map_t;

   // Fixed, non-linear offset-to-channel mapping; unlisted offsets are holes.
   function automatic port_map_t map_port(input logic [PORT_OFF_W-1:0] off);
      port_map_t m;
      m = '{hit: 1'b0, ch: '0};
      case (off)
         3'd7: m = '{hit: 1'b1, ch: 2'd0};
         3'd3: m = '{hit: 1'b1, ch: 2'd1};
         3'd1: m = '{hit: 1'b1, ch: 2'd2};
         3'd2: m = '{hit: 1'b1, ch: 2'd3};
         default: m = '{hit: 1'b0, ch: '0};
      endcase
      return m;
   endfunction
endpackage

// File: rtl/dma_pg_decode.sv
module dma_pg_decode
   import dma_pg_pkg::*;
(
   input  logic [PORT_OFF_W-1:0] off,
   output logic                  hit,
   output logic [CH_IDX_W-1:0]   ch
);
   port_map_t m;

   always_comb begin
      m   = map_port(off);
      hit = m.hit;
      ch  = m.ch;
   end
endmodule

// File: rtl/dma_pg_regs.sv
module dma_pg_regs #(
   parameter int NUM_CH       = 4,
   parameter int PG_W         = 8,
   parameter int CH_W         = 2,
   parameter bit HIGH_PAGE_EN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr,
   input  logic                   rd,
   input  logic                   bank_hi,
   input  logic                   hit,
   input  logic [CH_W-1:0]        ch,
   input  logic [PG_W-1:0]        wdata,
   output logic [NUM_CH*PG_W-1:0] lo_flat,
   output logic [NUM_CH*PG_W-1:0] hi_flat,
   output logic [PG_W-1:0]        rdata,
   output logic                   rd_err
);
   logic [PG_W-1:0] lo_q [NUM_CH];
   logic [PG_W-1:0] rd_val;
   logic            rd_nodec;
   logic            lo_we;

   assign lo_we = wr && hit && !bank_hi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CH; i++) lo_q[i] <= '0;
      end else if (lo_we) begin
         lo_q[ch] <= wdata;
      end
   end

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_lo_flat
         assign lo_flat[g*PG_W +: PG_W] = lo_q[g];
      end

      if (HIGH_PAGE_EN) begin : g_hi_bank
         logic [PG_W-1:0] hi_q [NUM_CH];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < NUM_CH; i++) hi_q[i] <= '0;
            end else if (wr && hit && bank_hi) begin
               hi_q[ch] <= wdata;
            end
         end
         for (genvar g = 0; g < NUM_CH; g++) begin : g_hi_flat
            assign hi_flat[g*PG_W +: PG_W] = hi_q[g];
         end
         assign rd_nodec = 1'b0;

         AST_HI_WRITE_KEEPS_8B: assert property (@(posedge clk) disable iff (!rst_n)
            wr && hit && bank_hi |=> hi_q[$past(ch)] == $past(wdata)); // R10
      end else begin : g_no_hi_bank
         assign hi_flat  = '0;
         assign rd_nodec = bank_hi;

         AST_HI_ABSENT_WR: assert property (@(posedge clk) disable iff (!rst_n)
            wr && bank_hi |=> $stable(lo_flat)); // R6
         AST_HI_ABSENT_RD: assert property (@(posedge clk) disable iff (!rst_n)
            rd && bank_hi |=> !rd_err && rdata == '0); // R6
      end
   endgenerate

   always_comb begin
      rd_val = lo_q[ch];
      if (bank_hi) rd_val = hi_flat[ch*PG_W +: PG_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata  <= '0;
         rd_err <= 1'b0;
      end else begin
         rd_err <= rd && !hit && !rd_nodec;
         if (rd) rdata <= (hit && !rd_nodec) ? rd_val : '0;
      end
   end

   AST_LO_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      lo_we |=> lo_q[$past(ch)] == $past(wdata)); // R1
   AST_HOLE_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      wr && !hit |=> $stable(lo_flat) && $stable(hi_flat)); // R2
   AST_HOLE_RD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      rd && !hit && !rd_nodec |=> rd_err && rdata == '0); // R2
   AST_ERR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |-> $past(rd)); // R2
endmodule

// File: rtl/dma_pg_compose.sv
module dma_pg_compose #(
   parameter int NUM_CH    = 4,
   parameter int CH_W      = 2,
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 16,
   parameter int PG_W      = 8,
   parameter bit WORD_MODE = 1'b0,
   localparam int WS       = WORD_MODE ? 1 : 0,
   localparam int EFF_W    = ADDR_W + WS,
   localparam int LEN_W    = CNT_W + 1 + WS,
   localparam int PA_W     = ADDR_W + 2*PG_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [CH_W-1:0]          ch_sel,
   input  logic [NUM_CH*ADDR_W-1:0] cur_addr,
   input  logic [NUM_CH*ADDR_W-1:0] cur_pos,
   input  logic [NUM_CH*CNT_W-1:0]  base_cnt,
   input  logic [NUM_CH-1:0]        ch_dir,
   input  logic [NUM_CH*PG_W-1:0]   lo_flat,
   input  logic [NUM_CH*PG_W-1:0]   hi_flat,
   output logic [PA_W-1:0]          phys_addr,
   output logic [LEN_W-1:0]         xfer_len
);
   localparam int LO_SHIFT = ADDR_W;
   localparam int HI_SHIFT = ADDR_W + PG_W;
   localparam logic [PG_W-1:0] HI_MASK = {1'b0, {(PG_W-1){1'b1}}};

   logic [ADDR_W-1:0] sel_addr, sel_pos;
   logic [CNT_W-1:0]  sel_cnt;
   logic [PG_W-1:0]   sel_lo, sel_hi;
   logic              sel_dec;
   logic [EFF_W-1:0]  start_b, eff_b;
   logic [PA_W-1:0]   phys_c;
   logic [LEN_W-1:0]  len_c;

   always_comb begin
      sel_addr = cur_addr[ch_sel*ADDR_W +: ADDR_W];
      sel_pos  = cur_pos[ch_sel*ADDR_W +: ADDR_W];
      sel_cnt  = base_cnt[ch_sel*CNT_W +: CNT_W];
      sel_lo   = lo_flat[ch_sel*PG_W +: PG_W];
      sel_hi   = hi_flat[ch_sel*PG_W +: PG_W];
      sel_dec  = ch_dir[ch_sel];
   end

   generate
      if (WORD_MODE) begin : g_word
         assign start_b = {sel_addr, 1'b0};
      end else begin : g_byte
         assign start_b = sel_addr;
      end
   endgenerate

   always_comb begin
      eff_b  = sel_dec ? (start_b - EFF_W'(sel_pos)) : (start_b + EFF_W'(sel_pos));
      phys_c = (PA_W'(sel_hi & HI_MASK) << HI_SHIFT)
             | (PA_W'(sel_lo) << LO_SHIFT)
             | PA_W'(eff_b);
      len_c  = (LEN_W'(sel_cnt) + LEN_W'(1)) << WS;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phys_addr <= '0;
         xfer_len  <= '0;
      end else begin
         phys_addr <= phys_c;
         xfer_len  <= len_c;
      end
   end
endmodule

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen #(
   parameter int NUM_CH       = 4,
   parameter int ADDR_W       = 16,
   parameter int CNT_W        = 16,
   parameter int PG_W         = 8,
   parameter bit HIGH_PAGE_EN = 1'b1,
   parameter bit WORD_MODE    = 1'b0,
   localparam int CH_W        = $clog2(NUM_CH),
   localparam int LEN_W       = CNT_W + 1 + (WORD_MODE ? 1 : 0),
   localparam int PA_W        = ADDR_W + 2*PG_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [2:0]               io_off,
   input  logic                     io_hi,
   input  logic                     io_wr,
   input  logic                     io_rd,
   input  logic [PG_W-1:0]          io_wdata,
   output logic [PG_W-1:0]          io_rdata,
   output logic                     io_err,
   input  logic [CH_W-1:0]          ch_sel,
   input  logic [NUM_CH*ADDR_W-1:0] cur_addr,
   input  logic [NUM_CH*ADDR_W-1:0] cur_pos,
   input  logic [NUM_CH*CNT_W-1:0]  base_cnt,
   input  logic [NUM_CH-1:0]        ch_dir,
   output logic [PA_W-1:0]          phys_addr,
   output logic [LEN_W-1:0]         xfer_len
);
   generate
      if (NUM_CH != 4) begin : g_bad_ch
         $error("dma_page_addr_gen: port map is fixed for four channels");
      end
      if (CH_W != dma_pg_pkg::CH_IDX_W) begin : g_bad_chw
         $error("dma_page_addr_gen: channel index width mismatch");
      end
      if (PG_W < 2) begin : g_bad_pg
         $error("dma_page_addr_gen: page width too small");
      end
   endgenerate

   logic              dec_hit;
   logic [CH_W-1:0]   dec_ch;
   logic [NUM_CH*PG_W-1:0] lo_flat, hi_flat;

   dma_pg_decode u_decode (
      .off (io_off),
      .hit (dec_hit),
      .ch  (dec_ch)
   );

   dma_pg_regs #(
      .NUM_CH       (NUM_CH),
      .PG_W         (PG_W),
      .CH_W         (CH_W),
      .HIGH_PAGE_EN (HIGH_PAGE_EN)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (io_wr),
      .rd      (io_rd),
      .bank_hi (io_hi),
      .hit     (dec_hit),
      .ch      (dec_ch),
      .wdata   (io_wdata),
      .lo_flat (lo_flat),
      .hi_flat (hi_flat),
      .rdata   (io_rdata),
      .rd_err  (io_err)
   );

   dma_pg_compose #(
      .NUM_CH    (NUM_CH),
      .CH_W      (CH_W),
      .ADDR_W    (ADDR_W),
      .CNT_W     (CNT_W),
      .PG_W      (PG_W),
      .WORD_MODE (WORD_MODE)
   ) u_compose (
      .clk       (clk),
      .rst_n     (rst_n),
      .ch_sel    (ch_sel),
      .cur_addr  (cur_addr),
      .cur_pos   (cur_pos),
      .base_cnt  (base_cnt),
      .ch_dir    (ch_dir),
      .lo_flat   (lo_flat),
      .hi_flat   (hi_flat),
      .phys_addr (phys_addr),
      .xfer_len  (xfer_len)
   );

   AST_ADDR_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) || phys_addr[PA_W-1] == 1'b0); // R3
endmodule

// File: tb/dma_page_addr_gen_tb.sv
module dma_page_addr_gen_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  io_off = '0;
   logic        io_hi = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [1:0]  ch_sel = '0;
   logic [63:0] cur_addr = '0, cur_pos = '0, base_cnt = '0;
   logic [3:0]  ch_dir = '0;

   logic [7:0]  rd_a, rd_n, rd_w;
   logic        err_a, err_n, err_w;
   logic [31:0] pa_a, pa_n, pa_w;
   logic [16:0] len_a, len_n;
   logic [17:0] len_w;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_page_addr_gen u_dut (
      .clk(clk), .rst_n(rst_n), .io_off(io_off), .io_hi(io_hi), .io_wr(io_wr),
      .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(rd_a), .io_err(err_a),
      .ch_sel(ch_sel), .cur_addr(cur_addr), .cur_pos(cur_pos), .base_cnt(base_cnt),
      .ch_dir(ch_dir), .phys_addr(pa_a), .xfer_len(len_a));

   dma_page_addr_gen #(.HIGH_PAGE_EN(1'b0)) u_dut_nohi (
      .clk(clk), .rst_n(rst_n), .io_off(io_off), .io_hi(io_hi), .io_wr(io_wr),
      .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(rd_n), .io_err(err_n),
      .ch_sel(ch_sel), .cur_addr(cur_addr), .cur_pos(cur_pos), .base_cnt(base_cnt),
      .ch_dir(ch_dir), .phys_addr(pa_n), .xfer_len(len_n));

   dma_page_addr_gen #(.WORD_MODE(1'b1)) u_dut_word (
      .clk(clk), .rst_n(rst_n), .io_off(io_off), .io_hi(io_hi), .io_wr(io_wr),
      .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(rd_w), .io_err(err_w),
      .ch_sel(ch_sel), .cur_addr(cur_addr), .cur_pos(cur_pos), .base_cnt(base_cnt),
      .ch_dir(ch_dir), .phys_addr(pa_w), .xfer_len(len_w));

   typedef struct packed {
      logic [1:0]  ch;
      logic [15:0] addr;
      logic [15:0] pos;
      logic        dec;
      logic [15:0] cnt;
      logic [31:0] phys;
      logic [16:0] len;
   } vec_t;

   // Pages: low ch0..3 = 12,34,56,78; high ch0..3 = 81,7F,00,FF
   localparam vec_t VECS [5] = '{
      '{2'd0, 16'h1000, 16'h0010, 1'b0, 16'h00FF, 32'h01121010, 17'h00100},
      '{2'd1, 16'hFFF0, 16'h0020, 1'b0, 16'hFFFF, 32'h7F340010, 17'h10000},
      '{2'd2, 16'h0100, 16'h0001, 1'b1, 16'h0000, 32'h005600FF, 17'h00001},
      '{2'd3, 16'h0000, 16'h0001, 1'b1, 16'h1234, 32'h7F78FFFF, 17'h01235},
      '{2'd0, 16'hABCD, 16'h0000, 1'b1, 16'h7FFF, 32'h0112ABCD, 17'h08000}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic io_write(input logic hi, input logic [2:0] off, input logic [7:0] d);
      @(negedge clk);
      io_hi = hi; io_off = off; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic io_read(input logic hi, input logic [2:0] off);
      @(negedge clk);
      io_hi = hi; io_off = off; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic set_chan(input logic [1:0] ch, input logic [15:0] a, input logic [15:0] p,
                           input logic d, input logic [15:0] c);
      cur_addr = '0; cur_pos = '0; base_cnt = '0; ch_dir = '0;
      cur_addr[ch*16 +: 16] = a;
      cur_pos[ch*16 +: 16]  = p;
      base_cnt[ch*16 +: 16] = c;
      ch_dir[ch] = d;
      ch_sel = ch;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8: reset state
      chk("R8 phys", pa_a, 0);
      chk("R8 len", len_a, 0);
      chk("R8 rdata", rd_a, 0);
      chk("R8 err", err_a, 0);
      io_read(1'b0, 3'd7);
      chk("R8 page after reset", rd_a, 0);

      // Program pages through the scrambled offsets
      io_write(1'b0, 3'd7, 8'h12);
      io_write(1'b0, 3'd3, 8'h34);
      io_write(1'b0, 3'd1, 8'h56);
      io_write(1'b0, 3'd2, 8'h78);
      io_write(1'b1, 3'd7, 8'h81);
      io_write(1'b1, 3'd3, 8'h7F);
      io_write(1'b1, 3'd1, 8'h00);
      io_write(1'b1, 3'd2, 8'hFF);

      io_read(1'b0, 3'd1);
      chk("R1 offset1->ch2 low", rd_a, 8'h56);
      io_read(1'b0, 3'd7);
      chk("R1 offset7->ch0 low", rd_a, 8'h12);
      io_read(1'b1, 3'd3);
      chk("R1 offset3->ch1 high", rd_a, 8'h7F);
      io_read(1'b1, 3'd7);
      chk("R10 high page 8 bits", rd_a, 8'h81);
      chk("R6 no high bank rdata", rd_n, 8'h00);
      chk("R6 no high bank err", err_n, 1'b0);

      // Vector table: composed address and length
      foreach (VECS[i]) begin
         @(negedge clk);
         set_chan(VECS[i].ch, VECS[i].addr, VECS[i].pos, VECS[i].dec, VECS[i].cnt);
         @(negedge clk);
         chk($sformatf("R3 R4 phys vec%0d", i), pa_a, VECS[i].phys);
         chk($sformatf("R7 len vec%0d", i), len_a, VECS[i].len);
         chk($sformatf("R6 phys no high vec%0d", i), pa_n, VECS[i].phys & 32'h00FFFFFF);
      end

      // R9: registered output holds until the next edge
      @(negedge clk);
      ch_sel = 2'd2;
      #1;
      chk("R9 before edge", pa_a, 32'h0112ABCD);
      @(negedge clk);
      chk("R9 after edge", pa_a, 32'h00560000);
      chk("R9 len after edge", len_a, 17'h1);

      // R5: word mode doubles the base address
      @(negedge clk);
      set_chan(2'd0, 16'h8000, 16'h0002, 1'b0, 16'h00FF);
      @(negedge clk);
      chk("R5 word inc", pa_w, 32'h01130002);
      chk("R7 word len", len_w, 18'h00200);
      @(negedge clk);
      set_chan(2'd0, 16'h0000, 16'h0002, 1'b1, 16'h00FF);
      @(negedge clk);
      chk("R5 R4 word dec wrap", pa_w, 32'h0113FFFE);

      // R2: writes to holes change nothing
      io_write(1'b0, 3'd4, 8'hEE);
      io_write(1'b1, 3'd0, 8'hEE);
      io_write(1'b0, 3'd6, 8'hEE);
      io_read(1'b0, 3'd1);
      chk("R2 ch2 low intact", rd_a, 8'h56);
      io_read(1'b0, 3'd2);
      chk("R2 ch3 low intact", rd_a, 8'h78);
      io_read(1'b0, 3'd3);
      chk("R2 ch1 low intact", rd_a, 8'h34);
      io_read(1'b1, 3'd7);
      chk("R2 ch0 high intact", rd_a, 8'h81);
      chk("R2 address intact", pa_a, 32'h0112FFFE);

      // R2: read from a hole
      io_read(1'b0, 3'd5);
      chk("R2 hole rdata", rd_a, 8'h00);
      chk("R2 hole err", err_a, 1'b1);
      @(negedge clk);
      chk("R2 err one cycle", err_a, 1'b0);

      // R11: read and write to the same port in one cycle
      @(negedge clk);
      io_off = 3'd2; io_hi = 1'b0; io_wdata = 8'h9A; io_wr = 1'b1; io_rd = 1'b1;
      @(negedge clk);
      io_wr = 1'b0; io_rd = 1'b0;
      chk("R11 old value on collision", rd_a, 8'h78);
      io_read(1'b0, 3'd2);
      chk("R11 new value next read", rd_a, 8'h9A);

      done = 1'b1;
      finish_run();
   end
endmodule